// File: doc/BRIEF.md
# Operand effective-address generator

This block resolves one instruction operand. A one-cycle start pulse presents a 6-bit mode code together with the current stack pointer, data pointer, interrupt-address register, program counter and the four general-purpose register values. The block answers with either a register reference or a memory address.

Register operands and register-indirect operands finish in the cycle after start. Stack-relative and data-relative operands also need an offset word from the instruction stream. For these the block raises a fetch request at the captured PC and waits for the word to arrive. It then adds the extended offset to the selected base pointer and pulses a PC-increment request so the sequencer moves past the extension word.

Every memory result is widened to a 24-bit physical address. The top byte is either zero or an externally supplied page byte, depending on a paging-enable input. Undefined codes finish at once with an illegal-mode flag.

Top module: `opnd_ea_gen`

## Requirements
- R1: Codes 0x00 to 0x10 are register operands. The cycle after start, done is 1, is_mem is 0, illegal is 0 and reg_sel equals the code. No fetch request is made.
- R2: Codes 0x11 to 0x18 are register-indirect. The cycle after start, done is 1 and is_mem is 1. The low 16 address bits are the value of R0, R1, R2, R3, SP, DP, IR or PC respectively (code minus 0x11 selects, in that order).
- R3: Codes 0x20 and 0x22 request a fetch with fetch_addr equal to the PC at start. The address is SP (0x20) or DP (0x22) plus bits 7:0 of the fetched word, sign-extended, modulo 2^16.
- R4: Codes 0x21 and 0x23 behave the same way but add the full 16-bit fetched word, zero-extended, to SP (0x21) or DP (0x23), modulo 2^16.
- R5: fetch_req stays 1 with a stable fetch_addr and done 0 until fetch_valid is sampled high. Done follows in the next cycle, and fetch_req is 0 from that cycle on.
- R6: pc_inc is 1 for exactly one cycle per fetched operand, in the same cycle as done, and never for other codes.
- R7: Codes 0x19 to 0x1F and 0x24 to 0x3F finish the cycle after start with illegal 1, is_mem 0 and no fetch request.
- R8: Address bits 23:16 are 0 when page_en was 0 at start, and equal page_byte as sampled at start when page_en was 1. Later changes to these inputs have no effect on the pending operand.
- R9: done is a single-cycle pulse, one per accepted start. A start that arrives while a fetch is outstanding is ignored and produces no done.
- R10: After synchronous reset, done, is_mem, illegal, pc_inc and fetch_req are 0, and reg_sel and phys_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving an operand |
| mode | input | 6 | Operand mode code |
| gpr_flat | input | 64 | R3..R0 values, R0 in bits 15:0 |
| sp | input | 16 | Stack pointer |
| dp | input | 16 | Data pointer |
| ir | input | 16 | Interrupt-address register |
| pc | input | 16 | Program counter |
| page_en | input | 1 | Paging enable |
| page_byte | input | 8 | Upper address byte used when paging is on |
| fetch_valid | input | 1 | Fetched word is present |
| fetch_data | input | 16 | Fetched extension word |
| fetch_req | output | 1 | Request for an extension word |
| fetch_addr | output | 16 | Address of the requested word |
| done | output | 1 | Result valid pulse |
| is_mem | output | 1 | Result is a memory address |
| reg_sel | output | 5 | Register selector for register operands |
| phys_addr | output | 24 | Physical effective address |
| pc_inc | output | 1 | Request to advance PC by one word |
| illegal | output | 1 | Undefined mode code |

## Verification
The bench targets sign extension of short offsets with bit 7 set and long offsets that wrap past 0xFFFF. A design that zero-extends the short offset, or carries into bit 16, places the operand in the wrong page or at the wrong offset. It also holds fetch_valid low for several cycles and then drops a stray start into the wait, with the page inputs flipped. A design that accepts the stray start emits an extra done, and one that reads the page byte late produces the wrong upper address byte. The boundary codes 0x10/0x11, 0x18/0x19, 0x1F/0x20 and 0x23/0x24 are all exercised, so an off-by-one decode surfaces as a wrong kind, a wrong register or a missing illegal flag.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;
  localparam int unsigned REG_LAST   = 16;
  localparam int unsigned IND_FIRST  = 17;
  localparam int unsigned IND_LAST   = 24;
  localparam int unsigned OFS_FIRST  = 32;
  localparam int unsigned OFS_LAST   = 35;
  localparam int unsigned IND_SEL_W  = $clog2(IND_LAST - IND_FIRST + 1);
  localparam int unsigned REG_SEL_W  = $clog2(REG_LAST + 1);

  typedef enum logic [1:0] {K_REG, K_IND, K_OFS, K_BAD} opnd_kind_e;

  typedef struct packed {
    opnd_kind_e             kind;
    logic                   use_dp;
    logic                   short_ofs;
    logic [IND_SEL_W-1:0]   ind_sel;
  } opnd_dec_t;
endpackage

// File: rtl/opnd_mode_dec.sv
module opnd_mode_dec
  import opnd_ea_pkg::*;
#(
  parameter int unsigned MODE_W = 6
) (
  input  logic [MODE_W-1:0] mode,
  output opnd_dec_t         dec
);
  localparam logic [MODE_W-1:0] C_REG_LAST  = MODE_W'(REG_LAST);
  localparam logic [MODE_W-1:0] C_IND_FIRST = MODE_W'(IND_FIRST);
  localparam logic [MODE_W-1:0] C_IND_LAST  = MODE_W'(IND_LAST);
  localparam logic [MODE_W-1:0] C_OFS_FIRST = MODE_W'(OFS_FIRST);
  localparam logic [MODE_W-1:0] C_OFS_LAST  = MODE_W'(OFS_LAST);

  logic [MODE_W-1:0] ind_off;
  logic [MODE_W-1:0] ofs_off;

  assign ind_off = mode - C_IND_FIRST;
  assign ofs_off = mode - C_OFS_FIRST;

  always_comb begin
    dec = '{kind: K_BAD, use_dp: 1'b0, short_ofs: 1'b0, ind_sel: '0};
    if (mode <= C_REG_LAST) begin
      dec.kind = K_REG;
    end else if (mode >= C_IND_FIRST && mode <= C_IND_LAST) begin
      dec.kind    = K_IND;
      dec.ind_sel = ind_off[IND_SEL_W-1:0];
    end else if (mode >= C_OFS_FIRST && mode <= C_OFS_LAST) begin
      // pairs: bit1 picks the base, bit0 picks long (1) or short (0) offset
      dec.kind      = K_OFS;
      dec.use_dp    = ofs_off[1];
      dec.short_ofs = ~ofs_off[0];
    end
  end

  always_comb begin
    if (dec.kind == K_IND) assert_ind_range_R2: assert (mode > C_REG_LAST && mode < C_OFS_FIRST);
  end
endmodule

// File: rtl/opnd_ind_mux.sv
module opnd_ind_mux #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC*DATA_W-1:0] src_flat,
  input  logic [IDX_W-1:0]          idx,
  output logic [DATA_W-1:0]         val
);
  logic [DATA_W-1:0] src [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign src[g] = src_flat[g*DATA_W +: DATA_W];
  end

  assign val = src[idx];
endmodule

// File: rtl/opnd_ofs_add.sv
module opnd_ofs_add #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] word,
  input  logic              short_ofs,
  output logic [DATA_W-1:0] sum
);
  localparam int unsigned PAD_W = DATA_W - SHORT_W;

  logic [DATA_W-1:0] ext;

  assign ext = short_ofs ? {{PAD_W{word[SHORT_W-1]}}, word[SHORT_W-1:0]} : word;
  assign sum = base + ext;
endmodule

// File: rtl/opnd_addr_wide.sv
module opnd_addr_wide #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned ADDR_W = DATA_W + PAGE_W
) (
  input  logic              pg_en,
  input  logic [PAGE_W-1:0] page,
  input  logic [DATA_W-1:0] ea,
  output logic [ADDR_W-1:0] phys
);
  assign phys = {(pg_en ? page : {PAGE_W{1'b0}}), ea};
endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
  import opnd_ea_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned MODE_W  = 6,
  parameter int unsigned NUM_GPR = 4,
  parameter int unsigned SHORT_W = 8,
  localparam int unsigned ADDR_W  = DATA_W + PAGE_W,
  localparam int unsigned NUM_SRC = NUM_GPR + 4,
  localparam int unsigned SEL_W   = REG_SEL_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [MODE_W-1:0]          mode,
  input  logic [NUM_GPR*DATA_W-1:0]  gpr_flat,
  input  logic [DATA_W-1:0]          sp,
  input  logic [DATA_W-1:0]          dp,
  input  logic [DATA_W-1:0]          ir,
  input  logic [DATA_W-1:0]          pc,
  input  logic                       page_en,
  input  logic [PAGE_W-1:0]          page_byte,
  input  logic                       fetch_valid,
  input  logic [DATA_W-1:0]          fetch_data,
  output logic                       fetch_req,
  output logic [DATA_W-1:0]          fetch_addr,
  output logic                       done,
  output logic                       is_mem,
  output logic [SEL_W-1:0]           reg_sel,
  output logic [ADDR_W-1:0]          phys_addr,
  output logic                       pc_inc,
  output logic                       illegal
);
  typedef enum logic {S_IDLE, S_FETCH} state_e;

  state_e            st;
  opnd_dec_t         dec;
  logic [DATA_W-1:0] base_q;
  logic              short_q;
  logic              pg_en_q;
  logic [PAGE_W-1:0] page_q;
  logic [DATA_W-1:0] ind_val;
  logic [DATA_W-1:0] ofs_sum;
  logic [DATA_W-1:0] ea_mux;
  logic              pg_mux;
  logic [PAGE_W-1:0] page_mux;
  logic [ADDR_W-1:0] phys_w;

  opnd_mode_dec #(.MODE_W(MODE_W)) u_dec (.mode(mode), .dec(dec));

  opnd_ind_mux #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_mux (
    .src_flat ({pc, ir, dp, sp, gpr_flat}),
    .idx      (dec.ind_sel),
    .val      (ind_val)
  );

  opnd_ofs_add #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_add (
    .base      (base_q),
    .word      (fetch_data),
    .short_ofs (short_q),
    .sum       (ofs_sum)
  );

  // idle: widen the indirect value with live page inputs; fetch: use captured ones
  assign ea_mux   = (st == S_IDLE) ? ind_val   : ofs_sum;
  assign pg_mux   = (st == S_IDLE) ? page_en   : pg_en_q;
  assign page_mux = (st == S_IDLE) ? page_byte : page_q;

  opnd_addr_wide #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_wide (
    .pg_en (pg_mux),
    .page  (page_mux),
    .ea    (ea_mux),
    .phys  (phys_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      base_q     <= '0;
      short_q    <= 1'b0;
      pg_en_q    <= 1'b0;
      page_q     <= '0;
      fetch_req  <= 1'b0;
      fetch_addr <= '0;
      done       <= 1'b0;
      is_mem     <= 1'b0;
      reg_sel    <= '0;
      phys_addr  <= '0;
      pc_inc     <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      done   <= 1'b0;
      pc_inc <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            pg_en_q <= page_en;
            page_q  <= page_byte;
            unique case (dec.kind)
              K_REG: begin
                done      <= 1'b1;
                is_mem    <= 1'b0;
                illegal   <= 1'b0;
                reg_sel   <= mode[SEL_W-1:0];
                phys_addr <= '0;
              end
              K_IND: begin
                done      <= 1'b1;
                is_mem    <= 1'b1;
                illegal   <= 1'b0;
                reg_sel   <= '0;
                phys_addr <= phys_w;
              end
              K_OFS: begin
                st         <= S_FETCH;
                fetch_req  <= 1'b1;
                fetch_addr <= pc;
                base_q     <= dec.use_dp ? dp : sp;
                short_q    <= dec.short_ofs;
              end
              default: begin
                done      <= 1'b1;
                is_mem    <= 1'b0;
                illegal   <= 1'b1;
                reg_sel   <= '0;
                phys_addr <= '0;
              end
            endcase
          end
        end
        S_FETCH: begin
          if (fetch_valid) begin
            st        <= S_IDLE;
            fetch_req <= 1'b0;
            done      <= 1'b1;
            pc_inc    <= 1'b1;
            is_mem    <= 1'b1;
            illegal   <= 1'b0;
            reg_sel   <= '0;
            phys_addr <= phys_w;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_cause_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start || fetch_valid));

  assert_pcinc_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    pc_inc |-> (done && is_mem));

  assert_pcinc_single_R6: assert property (@(posedge clk) disable iff (rst)
    pc_inc |=> !pc_inc);

  assert_illegal_nomem_R7: assert property (@(posedge clk) disable iff (rst)
    (done && illegal) |-> !is_mem);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !fetch_valid) |=> (fetch_req && !done));

  assert_req_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !fetch_valid) |=> $stable(fetch_addr));

  assert_req_release_R5: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_valid) |=> (!fetch_req && done));
endmodule

// File: tb/opnd_ea_gen_test.sv
`timescale 1ns/1ps
module opnd_ea_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [5:0]  mode_i = '0;
  logic [15:0] r0 = 16'h1111, r1 = 16'h2222, r2 = 16'h3333, r3 = 16'h4444;
  logic [15:0] sp_i = 16'h1000, dp_i = 16'h0005, ir_i = 16'hABCD, pc_i = 16'h0200;
  logic        page_en_i = 1'b0;
  logic [7:0]  page_i = 8'h00;
  logic        fetch_valid_i = 1'b0;
  logic [15:0] fetch_data_i = 16'hDEAD;
  logic        fetch_req_o, done_o, is_mem_o, pc_inc_o, illegal_o;
  logic [15:0] fetch_addr_o;
  logic [4:0]  reg_sel_o;
  logic [23:0] phys_o;

  always #4 clk = ~clk;

  opnd_ea_gen uut (
    .clk(clk), .rst(rst), .start(start_i), .mode(mode_i),
    .gpr_flat({r3, r2, r1, r0}), .sp(sp_i), .dp(dp_i), .ir(ir_i), .pc(pc_i),
    .page_en(page_en_i), .page_byte(page_i),
    .fetch_valid(fetch_valid_i), .fetch_data(fetch_data_i),
    .fetch_req(fetch_req_o), .fetch_addr(fetch_addr_o), .done(done_o),
    .is_mem(is_mem_o), .reg_sel(reg_sel_o), .phys_addr(phys_o),
    .pc_inc(pc_inc_o), .illegal(illegal_o)
  );

  typedef struct {
    logic        is_mem;
    logic        ill;
    logic [4:0]  sel;
    logic [23:0] addr;
    logic        pcinc;
    int          due;
    string       req;
  } exp_t;

  exp_t sbq[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [5:0] m, input logic [15:0] word);
    exp_t e;
    logic [15:0] regs [8];
    logic [15:0] base, off, a16;
    regs = '{r0, r1, r2, r3, sp_i, dp_i, ir_i, pc_i};
    e.is_mem = 1'b0; e.ill = 1'b0; e.sel = '0; e.addr = '0; e.pcinc = 1'b0;
    e.due = 0; e.req = "";
    if (m <= 6'h10) begin
      e.sel = m[4:0];
    end else if (m <= 6'h18) begin
      e.is_mem = 1'b1;
      e.addr = {(page_en_i ? page_i : 8'h00), regs[m - 6'h11]};
    end else if (m >= 6'h20 && m <= 6'h23) begin
      base = (m >= 6'h22) ? dp_i : sp_i;
      off  = (m == 6'h20 || m == 6'h22) ? {{8{word[7]}}, word[7:0]} : word;
      a16  = base + off;
      e.is_mem = 1'b1; e.pcinc = 1'b1;
      e.addr = {(page_en_i ? page_i : 8'h00), a16};
    end else begin
      e.ill = 1'b1;
    end
    return e;
  endfunction

  // monitor: pops one expected item for every done pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R9 done with nothing pending", 64'(done_o), 64'd0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(cyc == e.due, {e.req, " latency"}, 64'(cyc), 64'(e.due));
          check({is_mem_o, illegal_o, reg_sel_o, phys_o} == {e.is_mem, e.ill, e.sel, e.addr},
                {e.req, " result"}, 64'({is_mem_o, illegal_o, reg_sel_o, phys_o}),
                64'({e.is_mem, e.ill, e.sel, e.addr}));
          check(pc_inc_o == e.pcinc, {e.req, " R6 pc_inc"}, 64'(pc_inc_o), 64'(e.pcinc));
        end
      end else if (pc_inc_o) begin
        check(1'b0, "R6 pc_inc without done", 64'(pc_inc_o), 64'd0);
      end
    end
  end

  task automatic run_op(input logic [5:0] m, input int wt, input logic [15:0] word,
                        input bit poke, input string tag);
    exp_t e;
    bit fm;
    @(negedge clk);
    mode_i = m;
    e = predict(m, word);
    e.req = tag;
    fm = (m >= 6'h20 && m <= 6'h23);
    start_i = 1'b1;
    if (!fm) begin
      e.due = cyc + 1;
      sbq.push_back(e);
    end
    @(negedge clk);
    start_i = 1'b0;
    if (!fm) begin
      check(!fetch_req_o, {tag, " no fetch"}, 64'(fetch_req_o), 64'd0);
      return;
    end
    check(fetch_req_o == 1'b1, "R5 fetch request raised", 64'(fetch_req_o), 64'd1);
    check(fetch_addr_o == pc_i, "R3 fetch address is PC", 64'(fetch_addr_o), 64'(pc_i));
    for (int i = 0; i < wt; i++) begin
      if (poke && i == 0) begin
        start_i = 1'b1; mode_i = 6'h05;
        page_en_i = ~page_en_i; page_i = ~page_i;
      end
      @(negedge clk);
      start_i = 1'b0;
      check(fetch_req_o && !done_o, "R5 wait holds request", 64'({fetch_req_o, done_o}), 64'h2);
    end
    fetch_valid_i = 1'b1;
    fetch_data_i  = word;
    e.due = cyc + 1;
    sbq.push_back(e);
    @(negedge clk);
    fetch_valid_i = 1'b0;
    fetch_data_i  = 16'hDEAD;
    check(!fetch_req_o, "R5 request released", 64'(fetch_req_o), 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check({done_o, is_mem_o, illegal_o, pc_inc_o, fetch_req_o, reg_sel_o, phys_o} == '0,
          "R10 reset state", 64'({done_o, is_mem_o, illegal_o, pc_inc_o, fetch_req_o, reg_sel_o, phys_o}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!done_o && !fetch_req_o, "R10 idle after reset", 64'({done_o, fetch_req_o}), 64'd0);

    // R1 register operands, including the last code 0x10
    run_op(6'h00, 0, 16'h0, 0, "R1 reg 0x00");
    run_op(6'h07, 0, 16'h0, 0, "R1 reg 0x07");
    run_op(6'h0C, 0, 16'h0, 0, "R1 reg 0x0C");
    run_op(6'h10, 0, 16'h0, 0, "R1 reg 0x10");

    // R2 indirect through each source in order
    for (int k = 6'h11; k <= 6'h18; k++) run_op(6'(k), 0, 16'h0, 0, "R2 indirect");

    // R3 short signed offsets; R5 with varied waits
    run_op(6'h20, 0, 16'h12F0, 0, "R3 sp short negative");
    run_op(6'h20, 3, 16'hFF7F, 0, "R3 sp short positive");
    dp_i = 16'h0005;
    run_op(6'h22, 7, 16'h1280, 0, "R3 dp short wraps");

    // R4 long unsigned offsets with wrap
    sp_i = 16'h0003;
    run_op(6'h21, 1, 16'hFFFE, 0, "R4 sp long wraps");
    run_op(6'h23, 2, 16'h8000, 0, "R4 dp long");

    // R7 illegal boundaries
    run_op(6'h19, 0, 16'h0, 0, "R7 illegal 0x19");
    run_op(6'h1F, 0, 16'h0, 0, "R7 illegal 0x1F");
    run_op(6'h24, 0, 16'h0, 0, "R7 illegal 0x24");
    run_op(6'h3F, 0, 16'h0, 0, "R7 illegal 0x3F");

    // R8 paging
    page_en_i = 1'b1; page_i = 8'hA5;
    run_op(6'h13, 0, 16'h0, 0, "R8 paged indirect");
    pc_i = 16'h0300;
    run_op(6'h21, 2, 16'h0100, 0, "R8 paged long");
    page_en_i = 1'b0; page_i = 8'h3C;
    run_op(6'h17, 0, 16'h0, 0, "R8 unpaged upper zero");

    // R9 stray start during fetch plus R8 page change after start
    page_en_i = 1'b1; page_i = 8'h5A;
    run_op(6'h22, 4, 16'h0040, 1, "R9 R8 busy start ignored");
    page_en_i = 1'b0;

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R9 all results delivered", 64'(sbq.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule